// File: doc/BRIEF.md
# Single-Wire Slave Bit-Slot Timing Engine

This block is the physical timing layer of a slave on a single-wire, open-drain bus with one master. It watches the bus input, already synchronized to the system clock, and measures every low period with one counter started at the falling edge. From that measurement it decodes master write slots into bits and answers read slots by holding the line low for a 0. It also recognizes reset pulses and answers each one with a presence pulse. All durations are given in microseconds and converted to clock ticks through the `TICKS_PER_US` parameter.

Two speeds are supported. The upper protocol layer selects overdrive through `od_mode`, and the engine latches that choice at each falling edge. A reset low of 480 µs or more at either speed is reported on `rst_long`. The upper layer uses that signal to fall back to standard speed, and the presence pulse that follows uses standard timing. At overdrive, a reset low from 48 µs up to 480 µs is reported on `rst_short`, and the speed stays at overdrive. A digital glitch filter takes the place of analog switching thresholds. It applies only at standard speed.

The states are IDLE (line high, waiting), QUAL (standard-speed falling-edge qualification), SLOT (counting toward the sample point), TAIL (after the sample, waiting for the line to rise), PD_WAIT (delay after a reset low), PD_DRIVE (presence pulse) and PD_REL (waiting for the line to go high again). The transitions are as follows:
- IDLE→QUAL on a low at standard speed. IDLE→SLOT on a low at overdrive.
- QUAL→IDLE when the line rises too early. QUAL→SLOT once the low has been held long enough.
- SLOT→TAIL at the sample point.
- TAIL→IDLE on a rise that is not a reset. TAIL→PD_WAIT on a rise that ends a reset.
- PD_WAIT→PD_DRIVE after the presence delay.
- PD_DRIVE→PD_REL after the presence length.
- PD_REL→IDLE once the line is high.

Top module: `owt_slot_engine`

## Requirements
- R1: After reset, `pull_low`, `rx_valid`, `tx_ack`, `rst_short` and `rst_long` are all 0.
- R2: At standard speed with `tx_en`=0, the bus is sampled 30 µs after the falling edge. A low that lasts past that point gives a one-cycle `rx_valid` with `rx_bit`=0. A shorter low gives `rx_bit`=1.
- R3: At overdrive (`od_mode`=1 at the falling edge), the write sample point is 4 µs after the falling edge.
- R4: At standard speed, a low shorter than `GLITCH_CLKS` clocks is ignored and produces no pulse. At overdrive there is no filter, and a one-clock low is decoded as a 1 bit.
- R5: In a slot that starts with `tx_en`=1 and `tx_bit`=0, `pull_low` holds the line low until 30 µs (standard) or 4 µs (overdrive) after the falling edge. The slot then gives one `tx_ack` pulse and no `rx_valid`.
- R6: In a slot that starts with `tx_en`=1 and `tx_bit`=1, `pull_low` stays 0 and one `tx_ack` pulse follows.
- R7: At standard speed, a low of at least 480 µs gives a `rst_long` pulse when the line rises. A shorter low gives no reset pulse. Any low that passes the sample point is also reported as a 0 bit.
- R8: At overdrive, a low from 48 µs up to but not including 480 µs gives `rst_short`. A low below 48 µs gives no reset. A low of 480 µs or more gives `rst_long`.
- R9: After a standard-speed or long reset, `pull_low` rises 15 µs after the line goes high and stays high for 60 µs, covering 60–72 µs after the rise.
- R10: After a short overdrive reset, the presence pulse runs from 2 µs to 12 µs after the rise. After a long reset taken at overdrive, the standard timing of R9 applies.
- R11: The engine's own presence pulse is not decoded as a slot. After a reset, exactly one bit (the reset low's own 0) is reported, and the next write slot decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 1 | Synchronized bus level, 1 = high |
| od_mode | input | 1 | 1 selects overdrive timing, latched at each falling edge |
| tx_en | input | 1 | 1 makes the next slot a read slot driven by this slave |
| tx_bit | input | 1 | Bit to send in a read slot |
| pull_low | output | 1 | 1 pulls the open-drain line low |
| rx_valid | output | 1 | One-cycle strobe for a decoded write bit |
| rx_bit | output | 1 | Decoded write bit, valid with `rx_valid` |
| tx_ack | output | 1 | One-cycle strobe when a read slot has been served |
| rst_short | output | 1 | One-cycle strobe for a short overdrive reset |
| rst_long | output | 1 | One-cycle strobe for a reset of 480 µs or more |

## Verification
The bench probes the exact tick boundaries of the reset thresholds: one clock under and exactly at 480 µs, and at 48 µs at overdrive. A comparison that is off by one, or a missing overdrive threshold, would miss or invent a reset. It checks one-clock and two-clock lows at standard speed against a one-clock low at overdrive. A filter applied at the wrong speed would either lose real overdrive slots or decode glitches as 1 bits. It samples the wire inside and after the read-zero hold and the presence window. A hold that is too short, a presence pulse at the wrong speed, or a presence pulse misread as a new slot each shows up as a wrong line level or an extra decoded bit.

// File: rtl/owt_pkg.sv
package owt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUAL,
        ST_SLOT,
        ST_TAIL,
        ST_PD_WAIT,
        ST_PD_DRIVE,
        ST_PD_REL
    } owt_state_e;

endpackage

// File: rtl/owt_sat_counter.sv
module owt_sat_counter #(
    parameter int W    = 16,
    parameter int MAXV = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         inc,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] LIMIT = W'(MAXV);

    // load restarts the count at one observed clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= W'(1);
        end else if (inc && (q < LIMIT)) begin
            q <= q + W'(1);
        end
    end

endmodule

// File: rtl/owt_tick_sel.sv
module owt_tick_sel #(
    parameter int TICKS_PER_US = 100,
    parameter int CW           = 16,
    parameter int SAMPLE_STD   = 30,
    parameter int SAMPLE_OD    = 4,
    parameter int HOLD_STD     = 30,
    parameter int HOLD_OD      = 4,
    parameter int RST_OD       = 48,
    parameter int RST_STD      = 480,
    parameter int PDW_STD      = 15,
    parameter int PDW_OD       = 2,
    parameter int PDL_STD      = 60,
    parameter int PDL_OD       = 10
) (
    input  logic          fast,
    output logic [CW-1:0] t_sample,
    output logic [CW-1:0] t_hold,
    output logic [CW-1:0] t_rst,
    output logic [CW-1:0] t_pdw,
    output logic [CW-1:0] t_pdl
);

    localparam logic [CW-1:0] K_SAMPLE_S = CW'(SAMPLE_STD * TICKS_PER_US);
    localparam logic [CW-1:0] K_SAMPLE_F = CW'(SAMPLE_OD  * TICKS_PER_US);
    localparam logic [CW-1:0] K_HOLD_S   = CW'(HOLD_STD   * TICKS_PER_US);
    localparam logic [CW-1:0] K_HOLD_F   = CW'(HOLD_OD    * TICKS_PER_US);
    localparam logic [CW-1:0] K_RST_S    = CW'(RST_STD    * TICKS_PER_US);
    localparam logic [CW-1:0] K_RST_F    = CW'(RST_OD     * TICKS_PER_US);
    localparam logic [CW-1:0] K_PDW_S    = CW'(PDW_STD    * TICKS_PER_US);
    localparam logic [CW-1:0] K_PDW_F    = CW'(PDW_OD     * TICKS_PER_US);
    localparam logic [CW-1:0] K_PDL_S    = CW'(PDL_STD    * TICKS_PER_US);
    localparam logic [CW-1:0] K_PDL_F    = CW'(PDL_OD     * TICKS_PER_US);

    always_comb begin
        t_sample = fast ? K_SAMPLE_F : K_SAMPLE_S;
        t_hold   = fast ? K_HOLD_F   : K_HOLD_S;
        t_rst    = fast ? K_RST_F    : K_RST_S;
        t_pdw    = fast ? K_PDW_F    : K_PDW_S;
        t_pdl    = fast ? K_PDL_F    : K_PDL_S;
    end

endmodule

// File: rtl/owt_slot_engine.sv
module owt_slot_engine
    import owt_pkg::*;
#(
    parameter int TICKS_PER_US = 100,
    parameter int GLITCH_CLKS  = (TICKS_PER_US / 2 > 0) ? TICKS_PER_US / 2 : 1,
    parameter int LONG_RST_US  = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    input  logic od_mode,
    input  logic tx_en,
    input  logic tx_bit,
    output logic pull_low,
    output logic rx_valid,
    output logic rx_bit,
    output logic tx_ack,
    output logic rst_short,
    output logic rst_long
);

    localparam int LONG_TICKS = LONG_RST_US * TICKS_PER_US;
    localparam int CW         = $clog2(LONG_TICKS + 2);
    localparam int GLITCH_EFF = (GLITCH_CLKS > 1) ? GLITCH_CLKS : 1;
    localparam logic [CW-1:0] K_LONG  = CW'(LONG_TICKS);
    localparam logic [CW-1:0] K_G_M1  = CW'(GLITCH_EFF - 1);
    localparam bit            USE_QUAL = (GLITCH_EFF > 1);

    owt_state_e    st, st_n;
    logic [CW-1:0] cnt;
    logic          cnt_load, cnt_inc;
    logic          slot_fast, pd_fast, drive0, tx_mode;
    logic          edge_take, rst_take, pd_fast_n;
    logic          rx_set, ack_set, short_set, long_set;
    logic          in_pd, sel_fast;
    logic [CW-1:0] t_sample, t_hold, t_rst, t_pdw, t_pdl;

    owt_sat_counter #(
        .W    (CW),
        .MAXV (LONG_TICKS)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .inc   (cnt_inc),
        .q     (cnt)
    );

    assign in_pd    = (st == ST_PD_WAIT) || (st == ST_PD_DRIVE) || (st == ST_PD_REL);
    assign sel_fast = in_pd ? pd_fast : slot_fast;

    owt_tick_sel #(
        .TICKS_PER_US (TICKS_PER_US),
        .CW           (CW),
        .RST_STD      (LONG_RST_US)
    ) u_sel (
        .fast     (sel_fast),
        .t_sample (t_sample),
        .t_hold   (t_hold),
        .t_rst    (t_rst),
        .t_pdw    (t_pdw),
        .t_pdl    (t_pdl)
    );

    // next-state and event decode
    always_comb begin
        st_n      = st;
        cnt_load  = 1'b0;
        cnt_inc   = 1'b0;
        edge_take = 1'b0;
        rst_take  = 1'b0;
        pd_fast_n = pd_fast;
        rx_set    = 1'b0;
        ack_set   = 1'b0;
        short_set = 1'b0;
        long_set  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (!bus_in) begin
                    edge_take = 1'b1;
                    cnt_load  = 1'b1;
                    st_n      = (od_mode || !USE_QUAL) ? ST_SLOT : ST_QUAL;
                end
            end
            ST_QUAL: begin
                if (bus_in) begin
                    st_n = ST_IDLE;
                end else begin
                    cnt_inc = 1'b1;
                    if (cnt >= K_G_M1) begin
                        st_n = ST_SLOT;
                    end
                end
            end
            ST_SLOT: begin
                cnt_inc = 1'b1;
                if (cnt >= t_sample) begin
                    st_n = ST_TAIL;
                    if (tx_mode) begin
                        ack_set = 1'b1;
                    end else begin
                        rx_set = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                cnt_inc = 1'b1;
                if (bus_in) begin
                    if (cnt >= K_LONG) begin
                        long_set  = 1'b1;
                        rst_take  = 1'b1;
                        pd_fast_n = 1'b0;
                    end else if (slot_fast && (cnt >= t_rst)) begin
                        short_set = 1'b1;
                        rst_take  = 1'b1;
                        pd_fast_n = 1'b1;
                    end
                    if (rst_take) begin
                        cnt_inc  = 1'b0;
                        cnt_load = 1'b1;
                        st_n     = ST_PD_WAIT;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end
            end
            ST_PD_WAIT: begin
                cnt_inc = 1'b1;
                if (cnt >= t_pdw) begin
                    cnt_inc  = 1'b0;
                    cnt_load = 1'b1;
                    st_n     = ST_PD_DRIVE;
                end
            end
            ST_PD_DRIVE: begin
                cnt_inc = 1'b1;
                if (cnt >= t_pdl) begin
                    st_n = ST_PD_REL;
                end
            end
            ST_PD_REL: begin
                if (bus_in) begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state register and per-slot latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            slot_fast <= 1'b0;
            pd_fast   <= 1'b0;
            drive0    <= 1'b0;
            tx_mode   <= 1'b0;
        end else begin
            st <= st_n;
            if (edge_take) begin
                slot_fast <= od_mode;
                drive0    <= tx_en && !tx_bit;
                tx_mode   <= tx_en;
            end
            if (rst_take) begin
                pd_fast <= pd_fast_n;
            end
        end
    end

    // outputs: line drive from state, strobes registered
    always_comb begin
        pull_low = (st == ST_PD_DRIVE) ||
                   (((st == ST_SLOT) || (st == ST_TAIL)) && drive0 && (cnt < t_hold));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid  <= 1'b0;
            rx_bit    <= 1'b0;
            tx_ack    <= 1'b0;
            rst_short <= 1'b0;
            rst_long  <= 1'b0;
        end else begin
            rx_valid  <= rx_set;
            tx_ack    <= ack_set;
            rst_short <= short_set;
            rst_long  <= long_set;
            if (rx_set) begin
                rx_bit <= bus_in;
            end
        end
    end

endmodule

// File: rtl/owt_slot_engine_chk.sv
module owt_slot_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic tx_ack,
    input logic rst_short,
    input logic rst_long,
    input logic pull_low,
    input logic slot_fast
);

    // R2: each decoded bit is a single-cycle strobe
    a_r2_rx_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: a slot is either a write or a read, never both
    a_r5_rx_ack_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && tx_ack));

    // R7: a reset is reported as one kind only
    a_r7_reset_kind_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_short && rst_long));

    // R8: a short reset only exists in an overdrive slot
    a_r8_short_only_fast: assert property (@(posedge clk) disable iff (!rst_n)
        rst_short |-> slot_fast);

    // R9: the presence pulse waits after the line rises
    a_r9_presence_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_short || rst_long) |=> !pull_low);

endmodule

bind owt_slot_engine owt_slot_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .tx_ack    (tx_ack),
    .rst_short (rst_short),
    .rst_long  (rst_long),
    .pull_low  (pull_low),
    .slot_fast (slot_fast)
);

// File: tb/tb_owt_slot_engine.sv
`timescale 1ns/1ps
module tb_owt_slot_engine;

    localparam int TPU = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_drv = 1'b1;
    logic od_mode = 1'b0;
    logic tx_en = 1'b0;
    logic tx_bit = 1'b0;
    logic pull_low, rx_valid, rx_bit, tx_ack, rst_short, rst_long;
    logic bus;

    assign bus = m_drv & ~pull_low;

    always #2.5 clk = ~clk;

    owt_slot_engine #(.TICKS_PER_US(TPU)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_in    (bus),
        .od_mode   (od_mode),
        .tx_en     (tx_en),
        .tx_bit    (tx_bit),
        .pull_low  (pull_low),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit),
        .tx_ack    (tx_ack),
        .rst_short (rst_short),
        .rst_long  (rst_long)
    );

    int total = 0;
    int bad = 0;
    int n_rx = 0, n_ack = 0, n_sh = 0, n_lg = 0;
    logic last_bit = 1'b0;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (rx_valid) begin n_rx++; last_bit = rx_bit; end
        if (tx_ack) n_ack++;
        if (rst_short) n_sh++;
        if (rst_long) n_lg++;
    end

    typedef struct packed {
        logic        od;
        logic        txe;
        logic        txb;
        logic [11:0] low;
        logic        rx;
        logic        bt;
        logic        ack;
        logic        sh;
        logic        lg;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,12'd240, 1'b1,1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,12'd20,  1'b1,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,12'd4,   1'b1,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,12'd400, 1'b1,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,12'd32,  1'b1,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,12'd4,   1'b1,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,12'd1,   1'b0,1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,12'd2,   1'b1,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,12'd1,   1'b1,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b0,12'd4,   1'b0,1'b0,1'b1,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,12'd4,   1'b0,1'b0,1'b1,1'b0,1'b0},
        '{1'b1,1'b1,1'b0,12'd4,   1'b0,1'b0,1'b1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,12'd1920,1'b1,1'b0,1'b0,1'b0,1'b1},
        '{1'b0,1'b0,1'b0,12'd1919,1'b1,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,12'd192, 1'b1,1'b0,1'b0,1'b1,1'b0},
        '{1'b1,1'b0,1'b0,12'd191, 1'b1,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,12'd320, 1'b1,1'b0,1'b0,1'b1,1'b0},
        '{1'b1,1'b0,1'b0,12'd1920,1'b1,1'b0,1'b0,1'b0,1'b1}
    };

    function automatic string req_of(int i);
        case (i)
            0, 1, 2, 3:  return "R2";
            4, 5:        return "R3";
            6, 7, 8:     return "R4";
            9, 11:       return "R5";
            10:          return "R6";
            12, 13:      return "R7";
            default:     return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic slot_low(input int n);
        @(negedge clk);
        m_drv = 1'b0;
        repeat (n) @(negedge clk);
        m_drv = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r0, a0, s0, l0;
        // R1: state during and right after reset
        wait_n(3);
        check({pull_low, rx_valid, tx_ack, rst_short, rst_long} == 5'b0, "R1 in reset",
              {pull_low, rx_valid, tx_ack, rst_short, rst_long}, 0);
        rst_n = 1'b1;
        wait_n(5);
        check({pull_low, rx_valid, tx_ack, rst_short, rst_long} == 5'b0, "R1 after reset",
              {pull_low, rx_valid, tx_ack, rst_short, rst_long}, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            int exp_v, act_v;
            od_mode = VEC[i].od;
            tx_en   = VEC[i].txe;
            tx_bit  = VEC[i].txb;
            r0 = n_rx; a0 = n_ack; s0 = n_sh; l0 = n_lg;
            slot_low(int'(VEC[i].low));
            wait_n(400);
            exp_v = {VEC[i].rx, VEC[i].bt, VEC[i].ack, VEC[i].sh, VEC[i].lg};
            act_v = {(n_rx - r0) == 1, VEC[i].rx ? last_bit : 1'b0,
                     (n_ack - a0) == 1, (n_sh - s0) == 1, (n_lg - l0) == 1};
            if ((n_rx - r0) > 1 || (n_ack - a0) > 1 || (n_sh - s0) > 1 || (n_lg - l0) > 1)
                act_v = act_v | 32'h100;
            check(act_v == exp_v, req_of(i), act_v, exp_v);
        end
        od_mode = 1'b0; tx_en = 1'b0; tx_bit = 1'b0;

        // R9 and R11: standard reset, presence window, no self-decode
        r0 = n_rx;
        slot_low(1920);
        wait_n(41);
        check(pull_low == 1'b0, "R9 before presence", pull_low, 0);
        wait_n(200);
        check(pull_low == 1'b1, "R9 presence at 60us", pull_low, 1);
        wait_n(48);
        check(pull_low == 1'b1, "R9 presence at 72us", pull_low, 1);
        wait_n(32);
        check(pull_low == 1'b0, "R9 presence ended", pull_low, 0);
        wait_n(100);
        check(n_rx - r0 == 1, "R11 bits across reset", n_rx - r0, 1);
        slot_low(20);
        wait_n(300);
        check(n_rx - r0 == 2 && last_bit == 1'b1, "R11 slot after presence",
              (n_rx - r0) * 2 + int'(last_bit), 5);

        // R10: short overdrive reset, fast presence
        od_mode = 1'b1;
        slot_low(192);
        wait_n(5);
        check(pull_low == 1'b0, "R10 od before presence", pull_low, 0);
        wait_n(24);
        check(pull_low == 1'b1, "R10 od presence at 7us", pull_low, 1);
        wait_n(12);
        check(pull_low == 1'b1, "R10 od presence at 10us", pull_low, 1);
        wait_n(20);
        check(pull_low == 1'b0, "R10 od presence ended", pull_low, 0);
        wait_n(100);

        // R10: long reset from overdrive uses standard presence timing
        slot_low(1920);
        wait_n(29);
        check(pull_low == 1'b0, "R10 long reset no fast presence", pull_low, 0);
        wait_n(212);
        check(pull_low == 1'b1, "R10 long reset std presence", pull_low, 1);
        wait_n(200);
        od_mode = 1'b0;

        // R5: standard read-zero holds the wire
        tx_en = 1'b1; tx_bit = 1'b0;
        slot_low(4);
        wait_n(57);
        check(bus == 1'b0, "R5 std hold at 15us", bus, 0);
        wait_n(55);
        check(bus == 1'b0, "R5 std hold near 29us", bus, 0);
        wait_n(10);
        check(bus == 1'b1, "R5 std released after 30us", bus, 1);
        wait_n(300);

        // R6: read-one never pulls
        tx_bit = 1'b1;
        slot_low(4);
        wait_n(57);
        check(bus == 1'b1 && pull_low == 1'b0, "R6 read one wire high", bus, 1);
        wait_n(300);

        // R5: overdrive read-zero hold
        od_mode = 1'b1; tx_bit = 1'b0;
        slot_low(4);
        wait_n(5);
        check(bus == 1'b0, "R5 od hold at 2us", bus, 0);
        wait_n(12);
        check(bus == 1'b1, "R5 od released after 4us", bus, 1);
        wait_n(200);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule